// File: doc/BRIEF.md
# Trimmed Seconds Counter with Cross-Domain Write Handshake

This block keeps a free-running count that advances on a tick taken from a slow oscillator clock, nominally 32.768 kHz. The slow clock is unrelated to the bus clock. A programmable trim value sets the prescaler, and the tick comes every trim+1 slow cycles. The reset trim of 32767 therefore gives one tick per second. The count, the trim value and an enable bit are reached through a small register interface in the bus clock domain.

Writes to the count and to the trim value do not take effect at once. Each write is held in a bus-side register and crossed into the slow domain with a toggle request and acknowledge. A per-register pending flag stays set until the slow side has taken the value. The count is read from a separate read-only register. The slow domain captures the count and hands it back through the same kind of handshake, so a read never returns a mix of two values. A bus-side watchdog watches for slow-clock edges and reports whether the oscillator is running.

Software should treat the counter as usable only when the enable bit and the oscillator-running bit are both set.

Top module: `toy_counter`

## Requirements
- R1: After reset the count readback (address 1) is 0, the trim register (address 2) reads 32767, and status bits 0, 2 and 3 of address 3 are 0.
- R2: While enabled, the count increases by exactly 1 every trim+1 slow clock cycles and never by more than 1 per slow cycle, except on a load.
- R3: Bit 0 of address 3 is the enable. It is written through bit 0 of the write data and is 0 after reset. While it is 0 the count holds its value.
- R4: A write to address 0 sets status bit 2 of address 3 in the next bus cycle. The bit clears once the slow domain has loaded the value, after which address 1 returns the written value.
- R5: A count write made while status bit 2 is set is ignored and leaves the pending flag unchanged.
- R6: A trim write to address 2 sets status bit 3. Trim writes made while bit 3 is set are ignored, and address 2 reads back the last accepted trim value.
- R7: A count load restarts the prescaler, so the first tick after a load comes trim+1 slow cycles after it.
- R8: The count readback is never torn: between bus cycles it only stays the same or moves forward by a small step.
- R9: Status bit 1 of address 3 is set while slow-clock rising edges arrive within DET_WIN bus cycles of each other. It clears when no edge arrives for DET_WIN bus cycles.
- R10: Address 0 is write-only and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk_i | input | 1 | Slow oscillator clock that drives the counter |
| bus_we_i | input | 1 | Write strobe for one bus cycle |
| bus_addr_i | input | 2 | Register address: 0 count write, 1 count read, 2 trim, 3 control/status |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for bus_addr_i, combinational |

## Verification
A lost acknowledge toggle leaves a pending bit stuck at 1. A doubled request shows as a pending bit that never sets or as a second load. Both show at address 3 within a few slow cycles of the write. A wrong prescaler compare or a missing phase restart moves the tick rate or the first tick after a load. That shows as a count delta outside ±1 over a 160-slow-cycle window, or as an early increment within trim+1 slow cycles of a load. A torn or stale readback shows at address 1 as a backward step or a jump on the very next bus cycle.

// File: rtl/toy_pkg.sv
package toy_pkg;
  typedef enum logic [1:0] {
    REG_CNT_WR = 2'd0,
    REG_CNT_RD = 2'd1,
    REG_TRIM   = 2'd2,
    REG_CTRL   = 2'd3
  } reg_addr_e;

  localparam int ST_EN       = 0;
  localparam int ST_OSC_OK   = 1;
  localparam int ST_CNT_PEND = 2;
  localparam int ST_TRIM_PEND = 3;
endpackage

// File: rtl/toy_sync2.sv
module toy_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/toy_xfer.sv
// Toggle request/acknowledge transfer of a held word between two clock domains.
module toy_xfer #(
  parameter int W = 32
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic         pend_o,
  output logic         load_o,
  output logic [W-1:0] data_o
);
  logic         req_t, ack_s, req_s, req_d;
  logic [W-1:0] hold_q;

  // source side: accept only when idle
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_t  <= 1'b0;
      hold_q <= '0;
    end else if (wr_i && !pend_o) begin
      req_t  <= ~req_t;
      hold_q <= data_i;
    end
  end

  toy_sync2 #(.W(1)) u_ack_sync (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_d),
    .q_o   (ack_s)
  );

  assign pend_o = req_t ^ ack_s;

  // destination side: req_d doubles as the acknowledge toggle
  toy_sync2 #(.W(1)) u_req_sync (
    .clk_i (dst_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_t),
    .q_o   (req_s)
  );

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) req_d <= 1'b0;
    else         req_d <= req_s;
  end

  assign load_o = req_s ^ req_d;
  assign data_o = hold_q;  // stable while pending

  a_r4_pend_set: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (wr_i && !pend_o) |=> pend_o);
  a_r5_hold_stable: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    pend_o |=> $stable(hold_q));
  a_r8_single_load: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/toy_osc_det.sv
// Bus-domain watchdog for slow-clock activity.
module toy_osc_det #(
  parameter int WIN = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_clk_i,
  output logic ok_o
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          slow_s, slow_d, edge_w;
  logic [CW-1:0] gap_q;

  toy_sync2 #(.W(1)) u_clk_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (slow_clk_i),
    .q_o   (slow_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slow_d <= 1'b0;
    else         slow_d <= slow_s;
  end

  assign edge_w = slow_s && !slow_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      ok_o  <= 1'b0;
    end else if (edge_w) begin
      gap_q <= '0;
      ok_o  <= 1'b1;
    end else if (gap_q == CW'(WIN - 1)) begin
      ok_o  <= 1'b0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r9_edge_sets_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w |=> ok_o);
endmodule

// File: rtl/toy_core.sv
// Slow-domain prescaler and count.
module toy_core #(
  parameter int CNT_W    = 32,
  parameter int TRIM_W   = 16,
  parameter int TRIM_RST = 32767
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cnt_ld_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              trim_ld_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [TRIM_W-1:0] presc_q, trim_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tick_w;

  assign tick_w = presc_q >= trim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trim_q <= TRIM_W'(TRIM_RST);
    else if (trim_ld_i) trim_q <= trim_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (cnt_ld_i) begin
      presc_q <= '0;           // restart phase on load
      cnt_q   <= cnt_i;
    end else if (en_i) begin
      if (tick_w) begin
        presc_q <= '0;
        cnt_q   <= cnt_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_ld_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  a_r3_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/toy_counter.sv
module toy_counter
  import toy_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TRIM_W   = 16,
  parameter int TRIM_RST = 32767,
  parameter int DET_WIN  = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_clk_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o
);
  logic              en_q, en_s, osc_ok;
  logic [TRIM_W-1:0] trim_sh_q;
  logic [CNT_W-1:0]  rd_q;
  logic              cnt_we, trim_we;
  logic              cnt_pend, trim_pend, rd_pend;
  logic              cnt_ld, trim_ld, rd_ld;
  logic [CNT_W-1:0]  cnt_x, cnt_slow, rd_x;
  logic [TRIM_W-1:0] trim_x;

  assign cnt_we  = bus_we_i && (reg_addr_e'(bus_addr_i) == REG_CNT_WR);
  assign trim_we = bus_we_i && (reg_addr_e'(bus_addr_i) == REG_TRIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      trim_sh_q <= TRIM_W'(TRIM_RST);
      rd_q      <= '0;
    end else begin
      if (bus_we_i && reg_addr_e'(bus_addr_i) == REG_CTRL) en_q <= bus_wdata_i[ST_EN];
      if (trim_we && !trim_pend) trim_sh_q <= bus_wdata_i[TRIM_W-1:0];
      if (rd_ld) rd_q <= rd_x;
    end
  end

  toy_xfer #(.W(CNT_W)) u_cnt_xfer (
    .src_clk_i(clk_i), .dst_clk_i(slow_clk_i), .rst_ni(rst_ni),
    .wr_i(cnt_we), .data_i(bus_wdata_i),
    .pend_o(cnt_pend), .load_o(cnt_ld), .data_o(cnt_x)
  );

  toy_xfer #(.W(TRIM_W)) u_trim_xfer (
    .src_clk_i(clk_i), .dst_clk_i(slow_clk_i), .rst_ni(rst_ni),
    .wr_i(trim_we), .data_i(bus_wdata_i[TRIM_W-1:0]),
    .pend_o(trim_pend), .load_o(trim_ld), .data_o(trim_x)
  );

  // readback: slow side offers a fresh snapshot whenever the path is idle
  toy_xfer #(.W(CNT_W)) u_rd_xfer (
    .src_clk_i(slow_clk_i), .dst_clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(1'b1), .data_i(cnt_slow),
    .pend_o(rd_pend), .load_o(rd_ld), .data_o(rd_x)
  );

  toy_sync2 #(.W(1)) u_en_sync (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .d_i(en_q), .q_o(en_s)
  );

  toy_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_core (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .en_i(en_s),
    .cnt_ld_i(cnt_ld), .cnt_i(cnt_x),
    .trim_ld_i(trim_ld), .trim_i(trim_x),
    .cnt_o(cnt_slow)
  );

  toy_osc_det #(.WIN(DET_WIN)) u_osc (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_clk_i(slow_clk_i), .ok_o(osc_ok)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_addr_e'(bus_addr_i))
      REG_CNT_RD: bus_rdata_o = rd_q;
      REG_TRIM:   bus_rdata_o = CNT_W'(trim_sh_q);
      REG_CTRL: begin
        bus_rdata_o[ST_EN]        = en_q;
        bus_rdata_o[ST_OSC_OK]    = osc_ok;
        bus_rdata_o[ST_CNT_PEND]  = cnt_pend;
        bus_rdata_o[ST_TRIM_PEND] = trim_pend;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  a_r6_trim_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_we && trim_pend) |=> $stable(trim_sh_q));
  a_r8_rd_only_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ld |=> $stable(rd_q));
endmodule

// File: tb/toy_counter_tb_top.sv
`timescale 1ns/1ps
module toy_counter_tb_top;
  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        slow_run = 1'b1;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int          n_chk = 0, n_fail = 0;
  logic        mon_on = 1'b0;
  logic        have_prev = 1'b0;
  logic [31:0] prev = '0;
  logic        done = 1'b0;

  always #4 clk = ~clk;                                // 125 MHz
  always begin #20; if (slow_run) slow_clk = ~slow_clk; end  // 5 bus cycles per slow cycle

  toy_counter #(.CNT_W(32), .TRIM_W(16), .TRIM_RST(32767), .DET_WIN(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow_clk),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1; d = rdata; addr = 2'd1;
  endtask

  task automatic wait_clear(input int bitn);
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(2'd3, v);
      if (!v[bitn]) return;
    end
    chk("R4/R6 pending never cleared", v[bitn], 1'b0);
  endtask

  // every-clock readback model: count only moves forward by a small step
  always @(posedge clk) begin
    #2;
    if (mon_on && addr == 2'd1 && !we) begin
      if (have_prev) begin
        n_chk++;
        if (rdata < prev || rdata - prev > 32'd3) begin
          n_fail++;
          $display("FAIL R8 readback step actual=%0d expected=%0d..%0d", rdata, prev, prev + 3);
        end
      end
      prev = rdata; have_prev = 1'b1;
    end else have_prev = 1'b0;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0, c1;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd1, v); chk("R1 count after reset", v, 32'd0);
    rd(2'd2, v); chk("R1 trim after reset", v, 32'd32767);
    rd(2'd3, v); chk("R1 status after reset", v & 32'hD, 32'd0);
    // R10 write-only register
    rd(2'd0, v); chk("R10 addr0 reads zero", v, 32'd0);
    // R9 oscillator seen
    repeat (40) @(negedge clk);
    rd(2'd3, v); chk("R9 osc ok set", v[1], 1'b1);
    // R3 disabled: count holds
    repeat (200) @(negedge clk);
    rd(2'd1, v); chk("R3 count holds while disabled", v, 32'd0);
    // R6 trim write, second write blocked
    wr(2'd2, 32'd3);
    rd(2'd3, v); chk("R6 trim pending set", v[3], 1'b1);
    wr(2'd2, 32'd7);
    wait_clear(3);
    rd(2'd2, v); chk("R6 blocked trim write ignored", v, 32'd3);
    // R4/R5 count write, second write ignored
    wr(2'd0, 32'd100);
    rd(2'd3, v); chk("R4 count pending set", v[2], 1'b1);
    wr(2'd0, 32'd555);
    rd(2'd3, v); chk("R5 pending unchanged by ignored write", v[2], 1'b1);
    wait_clear(2);
    repeat (60) @(negedge clk);
    rd(2'd1, v); chk("R4/R5 loaded value", v, 32'd100);
    // R2 tick period trim+1 with trim=3
    wr(2'd3, 32'd1);
    repeat (100) @(negedge clk);
    mon_on = 1'b1;
    rd(2'd1, c0);
    repeat (799) @(negedge clk);
    rd(2'd1, c1);
    chk("R2 ticks in 160 slow cycles within 39..41",
        ((c1 - c0) >= 32'd39 && (c1 - c0) <= 32'd41) ? 32'd1 : 32'd0, 32'd1);
    // R7 load restarts prescaler phase, trim=63
    wr(2'd2, 32'd63);
    wait_clear(3);
    repeat (500) @(negedge clk);
    mon_on = 1'b0;
    wr(2'd0, 32'd5000);
    wait_clear(2);
    for (int i = 0; i < 200; i++) begin
      rd(2'd1, v);
      if (v == 32'd5000) break;
    end
    chk("R4 load visible", v, 32'd5000);
    repeat (200) @(negedge clk);
    rd(2'd1, v); chk("R7 no tick before trim+1 after load", v, 32'd5000);
    repeat (150) @(negedge clk);
    rd(2'd1, v); chk("R7 first tick after load", v, 32'd5001);
    mon_on = 1'b1;
    // R3 disable again: count holds
    wr(2'd3, 32'd0);
    mon_on = 1'b0;
    repeat (100) @(negedge clk);
    rd(2'd1, c0);
    repeat (400) @(negedge clk);
    rd(2'd1, c1); chk("R3 count frozen after disable", c1, c0);
    // R9 oscillator lost and regained
    slow_run = 1'b0;
    repeat (100) @(negedge clk);
    rd(2'd3, v); chk("R9 osc ok cleared", v[1], 1'b0);
    slow_run = 1'b1;
    repeat (50) @(negedge clk);
    rd(2'd3, v); chk("R9 osc ok restored", v[1], 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule